// File: doc/BRIEF.md
# Synchronous Serial Link Port

This block is a byte-wide, frame-less shift port on a small CPU register bus. Software loads a byte into the data register. It then writes the control register with the start bit set. The port swaps that byte with a peer: one bit leaves on the data output while one bit arrives on the data input, most significant bit first, eight times. No start bit, stop bit or parity surrounds the byte.

The shift clock has two sources. The internal source divides the system clock by a parameter (512 by default, which gives 8192 Hz from a 4.194304 MHz system clock) and drives the clock output pin. The external source takes edges from the clock input pin after synchronising them to the system clock. An external-clock exchange waits as long as no edges arrive. When the eighth bit has been received, the received byte replaces the data register, the start flag clears, and a one-cycle interrupt pulse is raised. The data output keeps the last bit sent until the next exchange moves it.

Top module: `sync_link_port`

## Requirements
- R1: After reset, the data register and the control register read 0x00, `sclk_out` and `sdata_out` are 1, and `irq` is 0.
- R2: The control register is at `bus_addr`=1 and the data register at `bus_addr`=0. Control bit 7 is the start/busy flag and bit 0 is the clock source (1 = internal divider, 0 = external pin). Its other bits read 0. Writing it with bit 7 set while idle starts an exchange.
- R3: With the internal source, `sclk_out` idles at 1 and goes low exactly eight times per exchange. Each low phase and each high phase lasts DIV_RATIO/2 cycles. `irq` is high in the cycle 8*DIV_RATIO clock edges after the edge that wrote the start bit.
- R4: Bits leave MSB first: `sdata_out` changes only on a falling shift-clock event. `sdata_in` is sampled on each rising event. After eight rising events, the data register holds the received byte, with the first sampled bit in bit 7.
- R5: `irq` is a single-cycle pulse, once per completed exchange.
- R6: The start flag (control bit 7) reads 0 in the same cycle that `irq` is high, and from then on until a new start.
- R7: With the external source, a level change on `sclk_in` acts at the third system clock edge after it. A high-to-low change is a falling event and a low-to-high change is a rising event. `sclk_out` stays at 1.
- R8: With the external source and no edges on `sclk_in`, the exchange never completes: bit 7 stays 1 and no `irq` occurs.
- R9: After an exchange, `sdata_out` holds the last bit sent until the first falling event of the next exchange.
- R10: With `sdata_in` held at 1, an internal-clock exchange leaves 0xFF in the data register.
- R11: While an exchange is in progress, writes to the data register and to the control register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idles high |
| sdata_in | input | 1 | Serial data from the peer |
| sdata_out | output | 1 | Serial data to the peer |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The port is driven with three input patterns. First, an internal-clock exchange with the input held high: this separates real sampling from a register that is only shifted, and it times the eight low pulses against the divider. Second, an internal-clock loopback, where the output wire feeds the input: this shows that bit order, the output-on-fall and sample-on-rise phases, and the final data register all match, and that a trailing 0 stays on the output. Third, an external-clock exchange: it first stalls with no edges while writes are attempted, then the bench plays slow edges carrying a different byte. This separates the synchroniser latency, the stall, the ignored writes and the capture of the transmitted bits by the peer.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int BYTE_W    = 8;
  localparam int START_BIT = 7;
  localparam int SRC_BIT   = 0;

  typedef enum logic {REG_DATA = 1'b0, REG_CTRL = 1'b1} reg_sel_e;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} clk_src_e;

  // Control word as software reads it: busy flag and clock source, zeros elsewhere.
  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic busy, input clk_src_e src);
    logic [BYTE_W-1:0] w;
    w            = '0;
    w[START_BIT] = busy;
    w[SRC_BIT]   = src;
    return w;
  endfunction
endpackage

// File: rtl/slp_divider.sv
module slp_divider #(
  parameter int DIV_RATIO = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fall_ev,
  output logic rise_ev,
  output logic sclk_lvl
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          phase_hi;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF - 1));
  assign fall_ev  = tick && phase_hi;
  assign rise_ev  = tick && !phase_hi;
  assign sclk_lvl = phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (!run) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (tick) begin
      cnt      <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk_lvl);

  // R3
  no_early_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sclk_lvl));
endmodule

// File: rtl/slp_edge_sync.sv
module slp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_ev,
  output logic rise_ev
);
  // pipe[STAGES-1] is the synchronised level; pipe[STAGES] is its previous value.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], pin};
  end

  assign fall_ev = !pipe[STAGES-1] &&  pipe[STAGES];
  assign rise_ev =  pipe[STAGES-1] && !pipe[STAGES];

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !fall_ev);

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !rise_ev);
endmodule

// File: rtl/slp_shifter.sv
module slp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         start,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         sin,
  output logic [W-1:0] data,
  output logic         sout,
  output logic         done
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  shreg;
  logic          sout_q;
  logic [BW-1:0] nbits;

  function automatic logic [W-1:0] shift_msb_first(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  assign done = rise_ev && (nbits == BW'(W - 1));
  assign data = shreg;
  assign sout = sout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sout_q <= 1'b1;
      nbits  <= '0;
    end else begin
      if (load)         shreg <= load_val;
      else if (rise_ev) shreg <= shift_msb_first(shreg, sin);

      if (fall_ev) sout_q <= shreg[W-1];

      if (start)        nbits <= '0;
      else if (rise_ev) nbits <= nbits + 1'b1;
    end
  end

  // R9
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sout));

  // R4
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (nbits == '0));
endmodule

// File: rtl/sync_link_port.sv
module sync_link_port import slp_pkg::*; #(
  parameter int DIV_RATIO   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              irq
);
  logic     busy_q;
  clk_src_e src_q;
  logic     irq_q;

  logic wr_data, wr_ctrl, start;
  logic run_int;
  logic int_fall, int_rise, int_lvl;
  logic ext_fall, ext_rise;
  logic fall_sel, rise_sel;
  logic shift_done;
  logic [BYTE_W-1:0] data_q;
  logic ctrl_bits_unused;

  assign ctrl_bits_unused = ^bus_wdata[BYTE_W-2:1];

  assign wr_data = bus_wr && (bus_addr == REG_DATA) && !busy_q;
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL) && !busy_q;
  assign start   = wr_ctrl && bus_wdata[START_BIT];
  assign run_int = busy_q && (src_q == SRC_INT);

  slp_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_int),
    .fall_ev  (int_fall),
    .rise_ev  (int_rise),
    .sclk_lvl (int_lvl)
  );

  slp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (sclk_in),
    .fall_ev (ext_fall),
    .rise_ev (ext_rise)
  );

  assign fall_sel = busy_q && ((src_q == SRC_INT) ? int_fall : ext_fall);
  assign rise_sel = busy_q && ((src_q == SRC_INT) ? int_rise : ext_rise);

  slp_shifter #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_data),
    .load_val (bus_wdata),
    .start    (start),
    .fall_ev  (fall_sel),
    .rise_ev  (rise_sel),
    .sin      (sdata_in),
    .data     (data_q),
    .sout     (sdata_out),
    .done     (shift_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      src_q  <= SRC_EXT;
      irq_q  <= 1'b0;
    end else begin
      if (start)           busy_q <= 1'b1;
      else if (shift_done) busy_q <= 1'b0;
      if (wr_ctrl) src_q <= clk_src_e'(bus_wdata[SRC_BIT]);
      irq_q <= shift_done;
    end
  end

  assign irq       = irq_q;
  assign sclk_out  = int_lvl;
  assign bus_rdata = (bus_addr == REG_CTRL) ? pack_ctrl(busy_q, src_q) : data_q;

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy_q && $past(busy_q)));

  // R8
  ext_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (src_q == SRC_EXT) && !ext_rise) |=> busy_q);

  // R11
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && !rise_sel) |=> ($stable(data_q) && $stable(src_q) && busy_q));

  // R7
  ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_EXT) |-> sclk_out);
endmodule

// File: tb/tb_sync_link_port.sv
module tb_sync_link_port;
  localparam int DIV  = 512;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_in = 1'b1;
  logic       sclk_out;
  logic       sin_drv = 1'b1;
  logic       loop = 1'b0;
  logic       sdata_in;
  logic       sdata_out;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int irq_total = 0;

  always #2.5 clk = ~clk;

  assign sdata_in = loop ? sdata_out : sin_drv;

  sync_link_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sdata_in(sdata_in), .sdata_out(sdata_out), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: time since start, bit index, pin history.
  logic [7:0] m_data, m_tx, m_rx;
  logic m_busy, m_sel, m_out, m_sclk, m_irq;
  logic q1, q2, q3;
  int m_t, m_b;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 8'h00; m_tx = 8'h00; m_rx = 8'h00;
      m_busy = 0; m_sel = 0; m_out = 1; m_sclk = 1; m_irq = 0;
      q1 = 1; q2 = 1; q3 = 1; m_t = 0; m_b = 0;
    end else begin
      logic fe, re, was_busy;
      fe = 0; re = 0; m_irq = 0; was_busy = m_busy;
      if (m_busy && m_sel) begin
        m_t++;
        if (m_t % DIV == HALF) fe = 1;
        else if (m_t % DIV == 0) re = 1;
      end else if (m_busy && !m_sel && (q2 != q3)) begin
        if (!q2) fe = 1; else re = 1;
      end
      q3 = q2; q2 = q1; q1 = sclk_in;
      if (fe) begin
        m_out = m_tx[7 - m_b];
        if (m_sel) m_sclk = 0;
      end
      if (re) begin
        m_rx = {m_rx[6:0], sdata_in};
        m_b++;
        if (m_sel) m_sclk = 1;
        if (m_b == 8) begin
          m_busy = 0; m_irq = 1; m_data = m_rx;
        end
      end
      if (bus_wr && !was_busy) begin
        if (bus_addr == 1'b0) m_data = bus_wdata;
        else begin
          m_sel = bus_wdata[0];
          if (bus_wdata[7]) begin
            m_busy = 1; m_t = 0; m_b = 0; m_tx = m_data; m_rx = 8'h00;
          end
        end
      end
    end
  end

  // Per-cycle comparison and watchdog.
  always @(negedge clk) begin
    cycles++;
    if (irq) irq_total++;
    if (rst_n) begin
      chk("R3", "sclk_out", sclk_out, m_sclk);
      chk("R9", "sdata_out", sdata_out, m_out);
      chk("R5", "irq", irq, m_irq);
      if (bus_addr) chk("R2", "control read", bus_rdata, {m_busy, 6'b0, m_sel});
      else if (!m_busy) chk("R4", "data read", bus_rdata, m_data);
    end
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic run_internal(output int cyc, output int lows, output int irqs);
    logic prev;
    bus_addr = 1'b1;
    cyc = 0; lows = 0; irqs = 0; prev = sclk_out;
    while (cyc < 3 * 8 * DIV) begin
      @(negedge clk);
      cyc++;
      if (prev && !sclk_out) lows++;
      prev = sclk_out;
      if (irq) begin
        irqs++;
        chk("R6", "busy at irq", bus_rdata[7], 1'b0);
        break;
      end
    end
  endtask

  initial begin
    int cyc, lows, irqs, irq_before;
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    #1 bus_addr = 1'b1; #1 chk("R1", "reset control", bus_rdata, 8'h00);
    bus_addr = 1'b0; #1 chk("R1", "reset data", bus_rdata, 8'h00);
    chk("R1", "reset sclk_out", sclk_out, 1'b1);
    chk("R1", "reset sdata_out", sdata_out, 1'b1);
    chk("R1", "reset irq", irq, 1'b0);
    @(negedge clk); #1 rst_n = 1'b1;

    // Internal clock, input tied high.
    wr(1'b0, 8'h75);
    wr(1'b1, 8'h81);
    run_internal(cyc, lows, irqs);
    chk("R3", "cycles to irq", cyc, 8 * DIV);
    chk("R3", "low pulses", lows, 8);
    chk("R5", "irq count", irqs, 1);
    @(negedge clk); #1 bus_addr = 1'b0; #1
    chk("R10", "received all ones", bus_rdata, 8'hFF);
    chk("R9", "last bit of 0x75", sdata_out, 1'b1);

    // Internal clock, loopback, byte ending in 0.
    loop = 1'b1;
    wr(1'b0, 8'h3A);
    wr(1'b1, 8'h81);
    run_internal(cyc, lows, irqs);
    chk("R4", "loopback cycles", cyc, 8 * DIV);
    loop = 1'b0; sin_drv = 1'b1;
    @(negedge clk); #1 bus_addr = 1'b0; #1
    chk("R4", "loopback byte", bus_rdata, 8'h3A);
    repeat (100) @(negedge clk);
    #1 chk("R9", "held last bit", sdata_out, 1'b0);
    bus_addr = 1'b1; #1 chk("R6", "start flag cleared", bus_rdata[7], 1'b0);

    // External clock: stall, ignored writes, then edges.
    wr(1'b0, 8'hC3);
    wr(1'b1, 8'h80);
    irq_before = irq_total;
    repeat (2000) @(negedge clk);
    #1 bus_addr = 1'b1; #1 chk("R8", "stalled busy", bus_rdata, 8'h80);
    chk("R8", "no irq while stalled", irq_total, irq_before);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h01);
    #1 bus_addr = 1'b1; #1 chk("R11", "control write ignored", bus_rdata, 8'h80);
    seen = 8'h00;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); #1;
      sclk_in = 1'b0; sin_drv = b[0] ? 1'b0 : 1'b1; // pattern 0xAA
      repeat (8) @(negedge clk);
      #1 seen = {seen[6:0], sdata_out};
      chk("R7", "sclk_out quiet", sclk_out, 1'b1);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    #1 bus_addr = 1'b1; #1 chk("R7", "ext done", bus_rdata, 8'h00);
    chk("R5", "one irq for ext", irq_total, irq_before + 1);
    bus_addr = 1'b0; #1 chk("R7", "ext received", bus_rdata, 8'hAA);
    chk("R11", "data write ignored, sent byte", seen, 8'hC3);
    chk("R9", "last ext bit", sdata_out, 1'b1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule